// File: doc/BRIEF.md
# Instruction Loop Buffer

This block sits between an instruction fetch unit and main memory. It keeps the eight 60-bit instruction words that were fetched most recently, each tagged with its word address. When the fetch unit asks for a word that is still held, the block answers from its own storage in the same cycle and does not touch memory. This lets a short loop run entirely from the buffer once its body has been fetched one time.

Each request is marked as sequential, conditional jump or unconditional jump. An unconditional jump always goes to memory and empties the buffer first. A conditional jump, whether it is taken or not, is looked up like any other request and leaves the stored words in place. As a result, a tight loop should close with a conditional jump whose condition is always true. On a miss the block issues a single memory read. It keeps its output valid low until the read data comes back. It then passes that word straight to the output and, in the same cycle, writes it over the oldest entry. Words are only stored when they have been requested; the block never reads ahead.

The fetch unit holds its request steady until `instr_valid` is high. Memory answers a read with a one-cycle `mem_rvalid` pulse, one or more cycles after `mem_req`. Addresses are word indices, so every jump target begins on a word boundary.

Top module: `loop_buf`

## Requirements
- R1: The buffer holds eight words of 60 bits. When a miss is filled, the new word replaces the entry that was filled earliest. A word address is never held in two entries at once.
- R2: On a miss, `mem_req` is high for one cycle with `mem_addr` equal to the requested word address, and `instr_valid` stays low in that cycle. In the cycle where `mem_rvalid` arrives, `instr_valid` goes high with `hit` low and `instr_word` equal to `mem_rdata`.
- R3: A request of kind sequential (`req_kind` = 2'b00) or conditional (2'b01) whose address is held gives `instr_valid` and `hit` high in the same cycle as the request. `instr_word` is then the stored word and `mem_req` stays low. This takes fewer cycles than a miss.
- R4: An unconditional jump (`req_kind` = 2'b10) always misses, even if its target is held, and it invalidates every entry. Any earlier address requested after it misses until it is fetched again.
- R5: A conditional jump, taken or falling through, leaves the stored entries unchanged, so later requests for held words still hit.
- R6: The block never reads ahead. While `req_valid` is low, `mem_req` and `instr_valid` stay low.
- R7: After reset, all entries are empty and `instr_valid`, `hit` and `mem_req` are low. The first request after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request present; held until instr_valid |
| req_kind | input | 2 | 00 sequential, 01 conditional jump, 10 unconditional jump |
| req_addr | input | 18 | Requested word address |
| mem_rdata | input | 60 | Memory read data |
| mem_rvalid | input | 1 | Memory read data valid, one cycle per read |
| mem_req | output | 1 | Memory read request, one cycle per miss |
| mem_addr | output | 18 | Memory read word address |
| instr_valid | output | 1 | instr_word is valid for the current request |
| instr_word | output | 60 | Instruction word returned to the fetch unit |
| hit | output | 1 | Word was served from the buffer |

## Verification
The assertions rely on a few assumptions about the inputs. The requester keeps its request stable until it is answered. Memory sends exactly one `mem_rvalid` per request and never in the same cycle as that request. No `mem_rvalid` arrives unless a read is outstanding. The bench meets these assumptions as follows. Each fetch is driven by a task that holds its inputs until `instr_valid` is seen. Memory is modelled by a fixed three-cycle countdown that starts only on `mem_req`. Reset is applied only when no read is outstanding.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int WORD_W = 60;
  localparam int ADDR_W = 18;
  localparam int DEPTH  = 8;

  typedef enum logic [1:0] {
    K_SEQ    = 2'b00,
    K_COND   = 2'b01,
    K_UNCOND = 2'b10
  } fetch_kind_e;
endpackage

// File: rtl/lb_entries.sv
module lb_entries #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 18,
  parameter int WORD_W = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] look_addr,
  output logic [DEPTH-1:0]  match_vec,
  output logic [WORD_W-1:0] rd_word
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [PW-1:0]     ptr_q, ptr_d;
  logic [ADDR_W-1:0] tag_q  [DEPTH];
  logic [WORD_W-1:0] data_q [DEPTH];

  // next state: flush clears all, a fill takes the oldest slot
  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (flush) begin
      vld_d = '0;
      ptr_d = '0;
    end else if (wr_en) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PW'(DEPTH-1)) ? '0 : ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  // payload storage, written only on fill
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[ptr_q]  <= wr_addr;
      data_q[ptr_q] <= wr_data;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign match_vec[gi] = vld_q[gi] && (tag_q[gi] == look_addr);
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) rd_word = rd_word | data_q[i];
    end
  end
endmodule

// File: rtl/lb_ctrl.sv
module lb_ctrl #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              any_match,
  input  logic              mem_rvalid,
  output logic              flush,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              mem_req,
  output logic              instr_valid,
  output logic              hit
);
  import lb_pkg::*;

  typedef enum logic {S_IDLE, S_WAIT} st_e;

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              look, uncond;

  always_comb begin
    look        = (st_q == S_IDLE) && req_valid;
    uncond      = (req_kind == K_UNCOND);
    hit         = look && !uncond && any_match;
    mem_req     = look && !hit;
    flush       = look && uncond;
    wr_en       = (st_q == S_WAIT) && mem_rvalid;
    wr_addr     = addr_q;
    instr_valid = hit || wr_en;
    st_d        = st_q;
    addr_d      = addr_q;
    if (mem_req) begin
      st_d   = S_WAIT;
      addr_d = req_addr;
    end else if (wr_en) begin
      st_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (mem_req) addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/loop_buf.sv
module loop_buf #(
  parameter int DEPTH  = lb_pkg::DEPTH,
  parameter int ADDR_W = lb_pkg::ADDR_W,
  parameter int WORD_W = lb_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              instr_valid,
  output logic [WORD_W-1:0] instr_word,
  output logic              hit
);
  logic              flush, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DEPTH-1:0]  match_vec;
  logic [WORD_W-1:0] rd_word;

  lb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .any_match(|match_vec), .mem_rvalid(mem_rvalid),
    .flush(flush), .wr_en(wr_en), .wr_addr(wr_addr),
    .mem_req(mem_req), .instr_valid(instr_valid), .hit(hit)
  );

  lb_entries #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ent (
    .clk(clk), .rst_n(rst_n),
    .flush(flush), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(mem_rdata),
    .look_addr(req_addr), .match_vec(match_vec), .rd_word(rd_word)
  );

  assign mem_addr   = req_addr;
  assign instr_word = wr_en ? mem_rdata : rd_word;
endmodule

// File: rtl/lb_check.sv
module lb_check #(
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic             mem_req,
  input logic             mem_rvalid,
  input logic             instr_valid,
  input logic             hit,
  input logic [DEPTH-1:0] match_vec
);
  p_unique_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  p_req_holds_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !instr_valid);

  p_miss_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !hit) |-> mem_rvalid);

  p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (instr_valid && !mem_req));

  p_uncond_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == lb_pkg::K_UNCOND) |-> !hit);

  p_no_ahead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_req && !instr_valid));
endmodule

bind loop_buf lb_check #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .instr_valid(instr_valid),
  .hit(hit), .match_vec(match_vec)
);

// File: tb/sim_loop_buf.sv
`timescale 1ns/1ps
module sim_loop_buf;
  localparam int AW  = 18;
  localparam int WW  = 60;
  localparam int LAT = 3;
  localparam int NV  = 22;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [WW-1:0] mem_rdata;
  logic          mem_rvalid;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          instr_valid;
  logic [WW-1:0] instr_word;
  logic          hit;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  loop_buf u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .mem_req(mem_req), .mem_addr(mem_addr), .instr_valid(instr_valid),
    .instr_word(instr_word), .hit(hit)
  );

  function automatic logic [WW-1:0] dat(input logic [AW-1:0] a);
    return {6'h2A, a, ~a, a ^ 18'h15A5A};
  endfunction

  // memory stub: fixed latency countdown
  int            cnt;
  logic [AW-1:0] m_addr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= 0;
      m_addr <= '0;
    end else if (mem_req) begin
      cnt    <= LAT;
      m_addr <= mem_addr;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end
  end
  assign mem_rvalid = (cnt == 1);
  assign mem_rdata  = dat(m_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind(2) addr(18) expected hit(1)
  localparam logic [20:0] VEC [NV] = '{
    {2'b00, 18'd100, 1'b0}, {2'b00, 18'd101, 1'b0},
    {2'b00, 18'd102, 1'b0}, {2'b00, 18'd103, 1'b0},
    {2'b01, 18'd100, 1'b1}, {2'b00, 18'd101, 1'b1},
    {2'b00, 18'd102, 1'b1}, {2'b00, 18'd103, 1'b1},
    {2'b01, 18'd104, 1'b0}, {2'b00, 18'd105, 1'b0},
    {2'b00, 18'd106, 1'b0}, {2'b00, 18'd107, 1'b0},
    {2'b00, 18'd108, 1'b0}, {2'b01, 18'd101, 1'b1},
    {2'b00, 18'd107, 1'b1}, {2'b01, 18'd100, 1'b0},
    {2'b01, 18'd102, 1'b1}, {2'b01, 18'd101, 1'b0},
    {2'b10, 18'd103, 1'b0}, {2'b00, 18'd104, 1'b0},
    {2'b01, 18'd103, 1'b1}, {2'b01, 18'd105, 1'b0}
  };

  task automatic fetch(input logic [1:0] k, input logic [AW-1:0] a,
                       input bit exp_hit, input string req);
    int cyc = 0;
    bit saw = 0;
    int nreq = 0;
    logic [AW-1:0] ra = '0;
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = k;
    req_addr  = a;
    #0.5;
    while (!instr_valid && cyc < 40) begin
      if (mem_req) begin
        saw = 1;
        nreq++;
        ra = mem_addr;
      end
      @(negedge clk);
      #0.5;
      cyc++;
    end
    chk(instr_valid, req, "instr_valid", instr_valid, 1);
    chk(hit == exp_hit, req, "hit", hit, exp_hit);
    chk(instr_word == dat(a), req, "instr_word", instr_word, dat(a));
    if (exp_hit) begin
      chk(cyc == 0 && !saw, req, "hit latency/mem_req", cyc, 0);
    end else begin
      chk(saw && nreq == 1 && ra == a, "R2", "mem_req addr", ra, a);
      chk(cyc == LAT, "R2", "miss latency", cyc, LAT);
    end
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_kind = 2'b00;
    req_addr = '0;
    repeat (3) @(negedge clk);
    #0.5;
    // R7: reset state
    chk(!instr_valid && !hit && !mem_req, "R7", "outputs after reset",
        {instr_valid, hit, mem_req}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: R1 fill/evict, R3 hits, R4 flush, R5 conditional keeps
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (VEC[i][20:19] == 2'b10) tag = "R4";
      else if (VEC[i][20:19] == 2'b01) tag = "R5";
      else if (VEC[i][0]) tag = "R3";
      else tag = "R1";
      fetch(VEC[i][20:19], VEC[i][18:1], VEC[i][0], tag);
    end

    // R6: no request means no memory traffic, no output
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      #0.5;
      chk(!mem_req && !instr_valid, "R6", "idle activity",
          {mem_req, instr_valid}, 0);
    end

    // R4: flush dropped 104..107 region, 106 was held before flush
    fetch(2'b00, 18'd106, 1'b0, "R4");

    // R7: reset empties the buffer, held word 103 misses afterwards
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    #0.5;
    chk(!instr_valid && !hit && !mem_req, "R7", "outputs in reset",
        {instr_valid, hit, mem_req}, 0);
    rst_n = 1'b1;
    fetch(2'b01, 18'd103, 1'b0, "R7");
    fetch(2'b01, 18'd103, 1'b1, "R5");

    @(negedge clk);
    req_valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule